// File: doc/BRIEF.md
# System Clock Source Selector

This block drives the core system clock from one of three inputs: an external serial bit clock, the crystal or master clock, or the output of an on-chip PLL. The control logic runs on the master clock. The source-select code, the safety bit and the PLL power-down request arrive on that clock. The PLL lock flag is asynchronous, so the block synchronises it.

Every change of source is made without glitches. The branch that is active now has its enable removed first. Each enable passes through a two-flop synchroniser clocked by its own source and then through a gate flop on the falling edge of that source. Only after the old branch reports that it is off does the control logic enable the new branch. The PLL is trusted only after its lock flag has stayed high for a qualification window. When safety is on and the PLL is not trusted, the block falls back to the master clock. A request to power the PLL down is held back until the PLL is no longer the active source.

The control state machine has three states. ST_RUN is steady state with one branch enabled. ST_DROP means the old branch enable has been removed and the block is waiting for its acknowledge to fall. ST_RAISE means the new branch enable is set and the block is waiting for its acknowledge to rise. The transitions are as follows:
- ST_RUN moves to ST_DROP when the wanted source differs from the current one.
- ST_DROP moves to ST_RAISE when the old acknowledge reads low.
- ST_RAISE moves to ST_RUN when the new acknowledge reads high.

Top module: `sysclk_selector`

## Requirements
- R1: `src_sel` picks the source. 2'b00 selects the master clock, 2'b01 the bit clock and 2'b10 the PLL clock. After a switch, `sys_clk` runs at the frequency of the selected source.
- R2: After reset, `sys_clk` follows the master clock, `pll_pdn` is 0 and `pll_unlock` is 1.
- R3: With `safe_en` = 1 and `pll_unlock` = 1, selecting the PLL yields the master clock. A PLL that loses lock while it is active is replaced by the master clock.
- R4: The reserved code 2'b11 selects the master clock.
- R5: `pll_unlock` goes to 0 only after the synchronised lock flag has been high for LOCK_CYCLES (16) consecutive master-clock cycles. A shorter high pulse leaves it at 1. It returns to 1 within 3 master-clock cycles of the flag falling.
- R6: With safety on, the PLL becomes the source again once lock is qualified.
- R7: With `safe_en` = 0, selecting the PLL yields the PLL clock whatever the lock state.
- R8: When `pll_pdn_req` is raised while the PLL is active, the block first switches to the master clock and only then asserts `pll_pdn`. `pll_pdn` falls on the master-clock edge after the request is removed.
- R9: `sys_clk` never shows a high or low pulse shorter than half a period of the fastest source.
- R10: The block never enables a new branch until the old branch has acknowledged that it is disabled. At most one branch is requested, and at most one acknowledges, at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_mst | input | 1 | Crystal/master clock; also clocks the control logic |
| clk_bit | input | 1 | External serial bit clock |
| clk_pll | input | 1 | PLL output clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 2 | Source select code (see R1, R4) |
| safe_en | input | 1 | Enables automatic fallback on PLL unlock |
| pll_locked | input | 1 | Raw asynchronous PLL lock flag |
| pll_pdn_req | input | 1 | Request to power the PLL down |
| sys_clk | output | 1 | Selected glitch-free system clock |
| pll_unlock | output | 1 | 1 while the PLL lock is not qualified |
| pll_pdn | output | 1 | PLL power-down, granted once the PLL is inactive |

## Verification
The bench builds the block with LOCK_CYCLES = 16. It runs the three clocks at periods of 4 ns, 10 ns and 6 ns, so every source can be told apart from the edges counted on `sys_clk` in a fixed window. Because the configuration is this small, the bench can sweep all sixteen ordered pairs of select codes and cover every branch-to-branch hand-over, including the reserved code. It also measures the shortest pulse on `sys_clk` across the whole run, which exposes any glitch at a hand-over.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
    localparam int NSRC = 3;
    localparam logic [1:0] IDX_MST = 2'd0;
    localparam logic [1:0] IDX_BIT = 2'd1;
    localparam logic [1:0] IDX_PLL = 2'd2;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_DROP  = 2'd1,
        ST_RAISE = 2'd2
    } sw_state_e;
endpackage

// File: rtl/sysclk_lock_qual.sv
module sysclk_lock_qual #(
    parameter int LOCK_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lock_raw,
    output logic lock_sync,
    output logic lock_ok
);
    localparam int CW = $clog2(LOCK_CYCLES + 1);

    logic          s1_q;
    logic          s2_q;
    logic [CW-1:0] cnt_q;
    logic          ok_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q  <= 1'b0;
            s2_q  <= 1'b0;
            cnt_q <= '0;
            ok_q  <= 1'b0;
        end else begin
            s1_q <= lock_raw;
            s2_q <= s1_q;
            if (!s2_q) begin
                cnt_q <= '0;
                ok_q  <= 1'b0;
            end else if (!ok_q) begin
                if (cnt_q == CW'(LOCK_CYCLES - 1)) ok_q <= 1'b1;
                else                               cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign lock_sync = s2_q;
    assign lock_ok   = ok_q;
endmodule

// File: rtl/sysclk_gate_branch.sv
module sysclk_gate_branch #(
    parameter bit RST_ON = 1'b0
) (
    input  logic clk_src,
    input  logic clk_mst,
    input  logic rst_n,
    input  logic req,
    output logic ack,
    output logic gclk
);
    logic s1_q, s2_q, gate_q, a1_q, a2_q;

    // enable synchroniser in the source's own domain
    always_ff @(posedge clk_src or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= RST_ON;
            s2_q <= RST_ON;
        end else begin
            s1_q <= req;
            s2_q <= s1_q;
        end
    end

    // gate changes only while the source is low
    always_ff @(negedge clk_src or negedge rst_n) begin
        if (!rst_n) gate_q <= RST_ON;
        else        gate_q <= s2_q;
    end

    // gate state returned to the control domain
    always_ff @(posedge clk_mst or negedge rst_n) begin
        if (!rst_n) begin
            a1_q <= RST_ON;
            a2_q <= RST_ON;
        end else begin
            a1_q <= gate_q;
            a2_q <= a1_q;
        end
    end

    assign ack  = a2_q;
    assign gclk = clk_src & gate_q;
endmodule

// File: rtl/sysclk_switch_fsm.sv
module sysclk_switch_fsm
    import sysclk_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      target,
    input  logic [N-1:0]    ack,
    output logic [N-1:0]    req,
    output logic [1:0]      cur,
    output sw_state_e       state
);
    sw_state_e  state_q, state_n;
    logic [1:0] cur_q, cur_n;
    logic [1:0] nxt_q, nxt_n;
    logic [N-1:0] req_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            cur_q   <= IDX_MST;
            nxt_q   <= IDX_MST;
        end else begin
            state_q <= state_n;
            cur_q   <= cur_n;
            nxt_q   <= nxt_n;
        end
    end

    // transitions
    always_comb begin
        state_n = state_q;
        cur_n   = cur_q;
        nxt_n   = nxt_q;
        unique case (state_q)
            ST_RUN: begin
                if (target != cur_q) begin
                    nxt_n   = target;
                    state_n = ST_DROP;
                end
            end
            ST_DROP: begin
                if (!ack[cur_q]) state_n = ST_RAISE;
            end
            ST_RAISE: begin
                if (ack[nxt_q]) begin
                    cur_n   = nxt_q;
                    state_n = ST_RUN;
                end
            end
            default: state_n = ST_RUN;
        endcase
    end

    // registered branch requests
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= N'(1) << IDX_MST;
        end else begin
            unique case (state_n)
                ST_RUN:   req_q <= N'(1) << cur_n;
                ST_RAISE: req_q <= N'(1) << nxt_n;
                default:  req_q <= '0;
            endcase
        end
    end

    assign req   = req_q;
    assign cur   = cur_q;
    assign state = state_q;
endmodule

// File: rtl/sysclk_selector.sv
module sysclk_selector
    import sysclk_pkg::*;
#(
    parameter int LOCK_CYCLES = 16
) (
    input  logic       clk_mst,
    input  logic       clk_bit,
    input  logic       clk_pll,
    input  logic       rst_n,
    input  logic [1:0] src_sel,
    input  logic       safe_en,
    input  logic       pll_locked,
    input  logic       pll_pdn_req,
    output logic       sys_clk,
    output logic       pll_unlock,
    output logic       pll_pdn
);
    logic [NSRC-1:0] clk_vec;
    logic [NSRC-1:0] req_vec;
    logic [NSRC-1:0] ack_vec;
    logic [NSRC-1:0] gclk_vec;
    logic            lock_sync;
    logic            lock_ok;
    logic            use_pll;
    logic [1:0]      target;
    logic [1:0]      cur_idx;
    sw_state_e       fsm_state;
    logic            pdn_q;

    assign clk_vec = {clk_pll, clk_bit, clk_mst};

    sysclk_lock_qual #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
        .clk       (clk_mst),
        .rst_n     (rst_n),
        .lock_raw  (pll_locked),
        .lock_sync (lock_sync),
        .lock_ok   (lock_ok)
    );

    assign use_pll = !pll_pdn_req && !(safe_en && !lock_ok);

    always_comb begin
        unique case (src_sel)
            2'b01:   target = IDX_BIT;
            2'b10:   target = use_pll ? IDX_PLL : IDX_MST;
            default: target = IDX_MST;
        endcase
    end

    sysclk_switch_fsm #(.N(NSRC)) u_fsm (
        .clk    (clk_mst),
        .rst_n  (rst_n),
        .target (target),
        .ack    (ack_vec),
        .req    (req_vec),
        .cur    (cur_idx),
        .state  (fsm_state)
    );

    for (genvar i = 0; i < NSRC; i++) begin : g_branch
        sysclk_gate_branch #(.RST_ON(i == int'(IDX_MST))) u_br (
            .clk_src (clk_vec[i]),
            .clk_mst (clk_mst),
            .rst_n   (rst_n),
            .req     (req_vec[i]),
            .ack     (ack_vec[i]),
            .gclk    (gclk_vec[i])
        );
    end

    // power-down granted only in steady state away from the PLL
    always_ff @(posedge clk_mst or negedge rst_n) begin
        if (!rst_n) pdn_q <= 1'b0;
        else        pdn_q <= pll_pdn_req && (fsm_state == ST_RUN) && (cur_idx != IDX_PLL);
    end

    assign sys_clk    = |gclk_vec;
    assign pll_unlock = !lock_ok;
    assign pll_pdn    = pdn_q;
endmodule

// File: rtl/sysclk_selector_chk.sv
module sysclk_selector_chk
    import sysclk_pkg::*;
(
    input logic            clk_mst,
    input logic            rst_n,
    input logic            pll_pdn,
    input logic            pll_unlock,
    input logic            safe_en,
    input logic            lock_sync,
    input logic [NSRC-1:0] req,
    input logic [NSRC-1:0] ack,
    input sw_state_e       state,
    input logic [1:0]      cur
);
    // R8
    pdn_pll_idle_chk: assert property (@(posedge clk_mst) disable iff (!rst_n)
        pll_pdn |-> !ack[IDX_PLL] && !req[IDX_PLL]);

    // R10
    req_onehot_chk: assert property (@(posedge clk_mst) disable iff (!rst_n)
        $onehot0(req));

    // R10
    ack_onehot_chk: assert property (@(posedge clk_mst) disable iff (!rst_n)
        $onehot0(ack));

    // R5
    lock_needs_flag_chk: assert property (@(posedge clk_mst) disable iff (!rst_n)
        !pll_unlock |-> $past(lock_sync));

    // R5
    unlock_on_drop_chk: assert property (@(posedge clk_mst) disable iff (!rst_n)
        $fell(lock_sync) |=> pll_unlock);

    // R3
    safe_fallback_chk: assert property (@(posedge clk_mst) disable iff (!rst_n)
        (state == ST_RUN && cur == IDX_PLL && safe_en && pll_unlock) |=> !req[IDX_PLL]);
endmodule

bind sysclk_selector sysclk_selector_chk u_chk (
    .clk_mst    (clk_mst),
    .rst_n      (rst_n),
    .pll_pdn    (pll_pdn),
    .pll_unlock (pll_unlock),
    .safe_en    (safe_en),
    .lock_sync  (lock_sync),
    .req        (req_vec),
    .ack        (ack_vec),
    .state      (fsm_state),
    .cur        (cur_idx)
);

// File: tb/test_sysclk_selector.sv
`timescale 1ns/1ps
module test_sysclk_selector;
    logic       clk_mst = 1'b0;
    logic       clk_bit = 1'b0;
    logic       clk_pll = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] src_sel = 2'b00;
    logic       safe_en = 1'b1;
    logic       pll_locked = 1'b0;
    logic       pll_pdn_req = 1'b0;
    logic       sys_clk;
    logic       pll_unlock;
    logic       pll_pdn;

    int checks = 0;
    int fails = 0;
    int edge_cnt = 0;
    real t_last = -1.0;
    real min_w = 1000.0;
    bit  done = 1'b0;

    always #2 clk_mst = ~clk_mst;   // 250 MHz
    always #5 clk_bit = ~clk_bit;
    always #3 clk_pll = ~clk_pll;

    sysclk_selector #(.LOCK_CYCLES(16)) i_sysclk_selector (
        .clk_mst     (clk_mst),
        .clk_bit     (clk_bit),
        .clk_pll     (clk_pll),
        .rst_n       (rst_n),
        .src_sel     (src_sel),
        .safe_en     (safe_en),
        .pll_locked  (pll_locked),
        .pll_pdn_req (pll_pdn_req),
        .sys_clk     (sys_clk),
        .pll_unlock  (pll_unlock),
        .pll_pdn     (pll_pdn)
    );

    always @(posedge sys_clk) edge_cnt++;

    always @(sys_clk) begin
        if (rst_n && t_last >= 0.0 && ($realtime - t_last) < min_w)
            min_w = $realtime - t_last;
        t_last = $realtime;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk_mst);
    endtask

    function automatic int exp_edges(input logic [1:0] sel, input bit pll_ok);
        if (sel == 2'b01) return 60;            // 10 ns period
        if (sel == 2'b10 && pll_ok) return 100; // 6 ns period
        return 150;                             // 4 ns period
    endfunction

    task automatic freq(input int exp, input string req);
        int c0;
        int n;
        c0 = edge_cnt;
        #600;
        n = edge_cnt - c0;
        chk(n >= exp - 1 && n <= exp + 1, req, n, exp);
        @(negedge clk_mst);
    endtask

    initial begin
        #400000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        cyc(10);
        rst_n = 1'b1;
        cyc(2);
        // R2 reset state
        chk(pll_unlock == 1'b1, "R2 unlock", pll_unlock, 1);
        chk(pll_pdn == 1'b0, "R2 pdn", pll_pdn, 0);
        freq(150, "R2 master after reset");

        // R1 bit clock
        src_sel = 2'b01; cyc(80);
        freq(60, "R1 bit clock");

        // R3 PLL selected, not locked, safety on
        src_sel = 2'b10; cyc(80);
        freq(150, "R3 fallback unlocked");

        // R5 short lock pulse
        pll_locked = 1'b1; cyc(10);
        pll_locked = 1'b0; cyc(10);
        chk(pll_unlock == 1'b1, "R5 short pulse", pll_unlock, 1);

        // R5/R6 qualification
        pll_locked = 1'b1; cyc(12);
        chk(pll_unlock == 1'b1, "R5 before window", pll_unlock, 1);
        cyc(18);
        chk(pll_unlock == 1'b0, "R5 after window", pll_unlock, 0);
        cyc(60);
        freq(100, "R6 return to PLL");

        // R3 lock loss while active
        pll_locked = 1'b0; cyc(4);
        chk(pll_unlock == 1'b1, "R5 unlock on drop", pll_unlock, 1);
        cyc(80);
        freq(150, "R3 fallback on loss");

        // R7 safety off
        safe_en = 1'b0; cyc(80);
        freq(100, "R7 PLL without safety");

        // R8 power-down request while PLL active
        pll_pdn_req = 1'b1; cyc(2);
        chk(pll_pdn == 1'b0, "R8 pdn held", pll_pdn, 0);
        cyc(80);
        chk(pll_pdn == 1'b1, "R8 pdn granted", pll_pdn, 1);
        freq(150, "R8 master during pdn");
        pll_pdn_req = 1'b0; cyc(1);
        chk(pll_pdn == 1'b0, "R8 pdn release", pll_pdn, 0);
        cyc(80);
        freq(100, "R8 PLL after release");

        // sweep all ordered pairs with the PLL qualified (R1, R4, R10)
        safe_en = 1'b1;
        pll_locked = 1'b1;
        cyc(40);
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                src_sel = 2'(a); cyc(80);
                src_sel = 2'(b); cyc(80);
                freq(exp_edges(2'(b), 1'b1), (b == 3) ? "R4 reserved code" : "R1 R10 sweep");
            end
        end

        // R9 shortest pulse, in ps
        chk(min_w >= 1.9, "R9 min pulse ps", int'(min_w * 1000.0), 2000);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule